// File: doc/BRIEF.md
# Non-Maskable Interrupt Recognition Unit

This unit sits between the external non-maskable interrupt pin and the instruction sequencer of a processor core. The pin may change with no fixed relation to the core clock, so it first passes through a short flop chain. The unit then looks for qualified rising edges. An edge qualifies only when the pin has been seen low for a minimum run of consecutive samples. Each qualified edge sets a sticky pending flag. The flag is offered to the core only on an instruction-boundary strobe, and it stays set until the core acknowledges it.

Sampling stops while the core is held by its initialisation pin or its debug-ready pin, and while the clock is stopped. It carries on in halt, shutdown, stop-grant and bus-hold conditions. An initialisation request is recorded whenever the init pin is seen high and is raised to the core once the core is out of stop-grant. Any pending interrupt waits behind it. When the core takes the init while an interrupt is already pending, the interrupt is offered straight away, without waiting for a boundary strobe, so that it is taken before the first fetch. From acknowledge until an end-of-handler strobe, new edges are still latched but are not offered.

Top module: `nmi_recog_unit`

## Requirements
- R1: A qualified rise of `nmi_pin` driven just before clock edge k is seen through a two-flop chain and sets the pending flag at edge k+2. With `insn_boundary` high, `nmi_req` is therefore high after edge k+2 and low after edge k+1.
- R2: Once set, the pending flag stays set while the pin goes low again, until `nmi_ack`.
- R3: A rising edge counts only if the synchronised pin was low on at least MIN_LOW (default 4) consecutive sampling edges just before it. A rise after a shorter low run is ignored, and the low-run counter saturates at MIN_LOW.
- R4: While `init_pin`, `prdy_pin` or `stop_clock` is high, no edge is latched and the low-run counter is held at zero. A rise during that time is not recognised later.
- R5: In stop-grant, sampling continues: an edge there is latched. `nmi_req` stays low while `stop_grant` or `stop_clock` is high.
- R6: `nmi_req` is high only while `insn_boundary` is high, except in the case covered by R10.
- R7: `nmi_ack` clears the pending flag at the next edge. A qualified edge in the same cycle leaves the flag set as a new request.
- R8: From the `nmi_ack` edge until an `nmi_done` edge, `nmi_req` stays low. Edges latched in that window stay pending and are offered after `nmi_done`.
- R9: A high `init_pin` records an init request. `init_req` is high while the record is set and `stop_grant` is low, and the record clears on `init_ack` when `init_pin` is low. While the record is set, `nmi_req` stays low.
- R10: If `init_ack` is taken while an interrupt is pending, that interrupt is offered on the following cycles whatever the value of `insn_boundary`, until `nmi_ack`.
- R11: `rst` (asynchronous, active high) clears the pending flag, the in-service state, the init record, the low-run counter and the R10 bypass. The synchronised pin reads as high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Asynchronous active-high reset |
| nmi_pin | input | 1 | External interrupt pin, may be asynchronous |
| init_pin | input | 1 | Initialisation request pin, level sensitive |
| prdy_pin | input | 1 | Debug-ready indication, suspends sampling |
| stop_grant | input | 1 | Core is in the stop-grant state |
| stop_clock | input | 1 | Core clock is stopped, suspends sampling |
| insn_boundary | input | 1 | Core is at an instruction boundary this cycle |
| nmi_ack | input | 1 | Core accepts the offered interrupt |
| nmi_done | input | 1 | Interrupt handler has finished |
| init_ack | input | 1 | Core accepts the init request |
| nmi_req | output | 1 | Pending interrupt offered to the core |
| init_req | output | 1 | Init service request to the core |

## Verification
The assertions take for granted that the core drives `nmi_ack` only in a cycle where `nmi_req` is high, `init_ack` only while `init_req` is high, and `nmi_done` only while a handler is in service. Under those conditions the pending, in-service and bypass flags follow the pattern the checks expect. The stimulus drives the other inputs first, lets the combinational request settle, and only then raises each acknowledge with a random choice gated by the matching request. `nmi_done` is gated by the bench's own in-service model. Pin low runs are drawn from a range that straddles the minimum low time, so both qualified and rejected edges occur.

// File: rtl/nmi_recog_pkg.sv
package nmi_recog_pkg;

    // Registered state of the low-run qualifier.
    typedef struct packed {
        logic [7:0] low_run;
    } qual_state_t;

    // Registered state of the request/ordering controller.
    typedef struct packed {
        logic pend;
        logic in_service;
        logic init_rec;
        logic fetch_bypass;
    } ctrl_state_t;

    localparam int unsigned QUAL_CNT_W = 8;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = async_in;
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/nmi_edge_qual.sv
module nmi_edge_qual
    import nmi_recog_pkg::*;
#(
    parameter int unsigned MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic sample_en,
    output logic edge_valid
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LOW_FULL = CW'(MIN_LOW);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!sample_en) begin
            run_d = '0;
        end else if (sync_in) begin
            run_d = '0;
        end else if (run_q != LOW_FULL) begin
            run_d = run_q + CW'(1);
        end
    end

    assign edge_valid = sample_en && sync_in && (run_q == LOW_FULL);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // Counter never passes its saturation point.
    p_run_saturates_r3: assert property (@(posedge clk) disable iff (rst)
        run_q <= LOW_FULL);

    // A qualified edge needs a low sample on the previous edge.
    p_edge_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        edge_valid |-> $past(!sync_in));

    // Suspended sampling empties the low run.
    p_gate_clears_run_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> (run_q == '0));

endmodule

// File: rtl/nmi_pend_ctrl.sv
module nmi_pend_ctrl
    import nmi_recog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_valid,
    input  logic init_pin,
    input  logic stop_grant,
    input  logic stop_clock,
    input  logic insn_boundary,
    input  logic nmi_ack,
    input  logic nmi_done,
    input  logic init_ack,
    output logic nmi_req,
    output logic init_req
);
    ctrl_state_t st_d, st_q;
    logic        offer_window;
    logic        init_taken;

    always_comb begin
        init_req     = st_q.init_rec && !stop_grant;
        offer_window = insn_boundary || st_q.fetch_bypass;
        nmi_req      = st_q.pend && !st_q.in_service && !st_q.init_rec
                       && !stop_grant && !stop_clock && offer_window;
        init_taken   = init_ack && init_req;
    end

    always_comb begin
        st_d = st_q;

        // Pending flag: a new edge wins over the acknowledge.
        if (edge_valid) begin
            st_d.pend = 1'b1;
        end else if (nmi_ack) begin
            st_d.pend = 1'b0;
        end

        // Handler window.
        if (nmi_ack) begin
            st_d.in_service = 1'b1;
        end else if (nmi_done) begin
            st_d.in_service = 1'b0;
        end

        // Init record: level on the pin keeps it set.
        if (init_pin) begin
            st_d.init_rec = 1'b1;
        end else if (init_taken) begin
            st_d.init_rec = 1'b0;
        end

        // Offer a held interrupt before the first fetch after init.
        if (nmi_ack) begin
            st_d.fetch_bypass = 1'b0;
        end else if (init_taken && st_q.pend) begin
            st_d.fetch_bypass = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Init is always ordered ahead of the interrupt.
    p_init_first_r9: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> !init_req);

    // Nothing is offered inside a handler.
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.in_service |-> !nmi_req);

    // Pending only ever rises from a qualified edge.
    p_pend_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pend) |-> $past(edge_valid));

    // Acknowledge without a coincident edge empties the flag.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && !edge_valid) |=> !st_q.pend);

    // Outside the bypass, requests appear only at boundaries.
    p_boundary_only_r6: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !insn_boundary) |-> st_q.fetch_bypass);

    // No offer while the core is parked.
    p_parked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (stop_grant || stop_clock) |-> !nmi_req);

endmodule

// File: rtl/nmi_recog_unit.sv
module nmi_recog_unit #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_pin,
    input  logic init_pin,
    input  logic prdy_pin,
    input  logic stop_grant,
    input  logic stop_clock,
    input  logic insn_boundary,
    input  logic nmi_ack,
    input  logic nmi_done,
    input  logic init_ack,
    output logic nmi_req,
    output logic init_req
);
    logic pin_sync;
    logic sample_en;
    logic edge_valid;

    assign sample_en = !init_pin && !prdy_pin && !stop_clock;

    nmi_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (nmi_pin),
        .sync_out (pin_sync)
    );

    nmi_edge_qual #(
        .MIN_LOW (MIN_LOW)
    ) u_qual (
        .clk        (clk),
        .rst        (rst),
        .sync_in    (pin_sync),
        .sample_en  (sample_en),
        .edge_valid (edge_valid)
    );

    nmi_pend_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .edge_valid    (edge_valid),
        .init_pin      (init_pin),
        .stop_grant    (stop_grant),
        .stop_clock    (stop_clock),
        .insn_boundary (insn_boundary),
        .nmi_ack       (nmi_ack),
        .nmi_done      (nmi_done),
        .init_ack      (init_ack),
        .nmi_req       (nmi_req),
        .init_req      (init_req)
    );

    // Suspended sampling never yields a qualified edge (R4).
    p_gated_no_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_en |-> !edge_valid);

endmodule

// File: tb/nmi_recog_unit_bench.sv
module nmi_recog_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_pin = 1'b0, init_pin = 1'b0, prdy_pin = 1'b0;
    logic stop_grant = 1'b0, stop_clock = 1'b0, insn_boundary = 1'b0;
    logic nmi_ack = 1'b0, nmi_done = 1'b0, init_ack = 1'b0;
    logic nmi_req, init_req;

    int checks = 0;
    int failures = 0;
    string phase = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_recog_unit u_nmi_recog_unit (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .init_pin(init_pin),
        .prdy_pin(prdy_pin), .stop_grant(stop_grant), .stop_clock(stop_clock),
        .insn_boundary(insn_boundary), .nmi_ack(nmi_ack), .nmi_done(nmi_done),
        .init_ack(init_ack), .nmi_req(nmi_req), .init_req(init_req)
    );

    // Reference model built from the requirements.
    logic m_s1 = 1'b1, m_s2 = 1'b1;
    int   m_run = 0;
    logic m_pend = 1'b0, m_busy = 1'b0, m_init = 1'b0, m_byp = 1'b0;

    function automatic logic exp_init_req();
        return m_init && !stop_grant;
    endfunction

    function automatic logic exp_nmi_req();
        return m_pend && !m_busy && !m_init && !stop_grant && !stop_clock
               && (insn_boundary || m_byp);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_run <= 0;
            m_pend <= 1'b0; m_busy <= 1'b0; m_init <= 1'b0; m_byp <= 1'b0;
        end else begin
            logic en, ev, itk;
            en  = !init_pin && !prdy_pin && !stop_clock;
            ev  = en && m_s2 && (m_run == MIN_LOW);
            itk = init_ack && exp_init_req();
            m_s1 <= nmi_pin;
            m_s2 <= m_s1;
            if (!en || m_s2) m_run <= 0;
            else if (m_run < MIN_LOW) m_run <= m_run + 1;
            if (ev) m_pend <= 1'b1; else if (nmi_ack) m_pend <= 1'b0;
            if (nmi_ack) m_busy <= 1'b1; else if (nmi_done) m_busy <= 1'b0;
            if (init_pin) m_init <= 1'b1; else if (itk) m_init <= 1'b0;
            if (nmi_ack) m_byp <= 1'b0; else if (itk && m_pend) m_byp <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: inputs sampled at posedge, outputs compared at negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(phase, nmi_req, exp_nmi_req(), "nmi_req vs model");
        chk(phase, init_req, exp_init_req(), "init_req vs model");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1357);
        ticks(3);
        rst = 1'b0;
        // R11: reset state
        chk("R11", nmi_req, 1'b0, "nmi_req after reset");
        chk("R11", init_req, 1'b0, "init_req after reset");

        // R1 / R2: latency and persistence
        phase = "R1";
        insn_boundary = 1'b1;
        ticks(8);
        nmi_pin = 1'b1;
        tick(); tick();
        chk("R1", nmi_req, 1'b0, "nmi_req after two edges");
        tick();
        chk("R1", nmi_req, 1'b1, "nmi_req after three edges");
        phase = "R2";
        nmi_pin = 1'b0;
        ticks(3);
        chk("R2", nmi_req, 1'b1, "pending survives pin low");

        // R6: boundary gating
        phase = "R6";
        insn_boundary = 1'b0; #1;
        chk("R6", nmi_req, 1'b0, "no offer off boundary");
        insn_boundary = 1'b1; #1;
        chk("R6", nmi_req, 1'b1, "offer on boundary");

        // R7 / R8: acknowledge and handler window
        phase = "R7";
        nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
        chk("R7", nmi_req, 1'b0, "cleared by ack");
        phase = "R8";
        ticks(2);
        nmi_pin = 1'b1; ticks(4); nmi_pin = 1'b0;
        chk("R8", nmi_req, 1'b0, "held during handler");
        nmi_done = 1'b1; tick(); nmi_done = 1'b0;
        chk("R8", nmi_req, 1'b1, "offered after done");
        nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
        nmi_done = 1'b1; tick(); nmi_done = 1'b0;

        // R3: minimum low time
        phase = "R3";
        nmi_pin = 1'b1; ticks(3);
        nmi_pin = 1'b0; ticks(3);
        nmi_pin = 1'b1; ticks(6);
        chk("R3", nmi_req, 1'b0, "three low samples rejected");
        nmi_pin = 1'b0; ticks(4);
        nmi_pin = 1'b1; ticks(3);
        chk("R3", nmi_req, 1'b1, "four low samples accepted");
        nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
        nmi_done = 1'b1; tick(); nmi_done = 1'b0;

        // R4: gating by debug-ready
        phase = "R4";
        nmi_pin = 1'b0; ticks(6);
        prdy_pin = 1'b1; nmi_pin = 1'b1; ticks(5);
        prdy_pin = 1'b0; ticks(5);
        chk("R4", nmi_req, 1'b0, "edge under prdy ignored");

        // R5 / R9 / R10: stop-grant, init ordering, prefetch bypass
        phase = "R5";
        nmi_pin = 1'b0; ticks(6);
        stop_grant = 1'b1; nmi_pin = 1'b1; ticks(4);
        chk("R5", nmi_req, 1'b0, "quiet in stop-grant");
        phase = "R9";
        init_pin = 1'b1; ticks(2); init_pin = 1'b0; ticks(2);
        chk("R9", init_req, 1'b0, "init held in stop-grant");
        stop_grant = 1'b0; insn_boundary = 1'b0; #1;
        chk("R9", init_req, 1'b1, "init after stop-grant");
        chk("R9", nmi_req, 1'b0, "nmi behind init");
        phase = "R10";
        init_ack = 1'b1; tick(); init_ack = 1'b0;
        chk("R10", nmi_req, 1'b1, "nmi offered before fetch");
        nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
        nmi_done = 1'b1; tick(); nmi_done = 1'b0;

        // R11: reset in the middle of a pending request
        phase = "R11";
        nmi_pin = 1'b0; insn_boundary = 1'b1; ticks(6);
        nmi_pin = 1'b1; ticks(3);
        rst = 1'b1; tick(); rst = 1'b0; tick();
        chk("R11", nmi_req, 1'b0, "reset drops pending");

        // Random mix, checked cycle by cycle against the model.
        phase = "R7";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) nmi_pin = ~nmi_pin;
            init_pin      = ($urandom_range(0, 60) == 0);
            prdy_pin      = ($urandom_range(0, 40) == 0);
            stop_clock    = ($urandom_range(0, 50) == 0);
            if ($urandom_range(0, 80) == 0) stop_grant = ~stop_grant;
            insn_boundary = $urandom_range(0, 2) != 0;
            nmi_done      = m_busy && ($urandom_range(0, 3) == 0);
            #1;
            nmi_ack  = nmi_req && ($urandom_range(0, 1) == 1);
            init_ack = init_req && ($urandom_range(0, 1) == 1);
            tick();
            nmi_ack = 1'b0; init_ack = 1'b0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule